// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a real address using a small set of programmable block mappings. Each mapping covers one power-of-two sized block, from 128 KiB up to 256 MiB. The mappings are held in two banks. Instruction fetches search one bank. Data loads and data stores search the other. Software loads a mapping through a single-cycle write port that names the bank, the index and every field of the entry.

Every entry of the selected bank is compared against the address in the same cycle. The lowest-indexed entry that is valid and matches wins. Only the first `cfgCount` entries take part in the search. The winning entry supplies the upper real address bits. Its stored protection is then checked against the kind of access.

The result is registered and appears one cycle after the request. It reports one of three outcomes: granted, protection fault, or no match. A no-match result lets the surrounding logic fall back to a page-based translation. That fallback lies outside this block.

Top module: `batMatch`

## Requirements
- R1: Access type code 2 (fetch) searches the instruction bank. Codes 1 (store), 0 (load) and 3 (handled as a load) search the data bank. A mapping written to one bank never produces a hit for an access that searches the other bank.
- R2: An entry can match only when address bits 31:28 equal the entry's 4-bit upper page field exactly.
- R3: An entry matches in its lower part when (address bits 27:17 AND NOT blockMask) equals the entry's 11-bit lower page field. blockMask bit i masks address bit 17+i.
- R4: With reqUser=1 an entry counts as valid only if its user-valid bit is set. With reqUser=0 it counts as valid only if its supervisor-valid bit is set.
- R5: Only entries with index below cfgCount are searched. When several valid entries match, the lowest index wins.
- R6: On a hit, the real address is formed as follows. Bits 31:28 come from frame bits 14:11. Bits 27:17 are (frame bits 10:0 AND NOT blockMask) OR (address bits 27:17 AND blockMask). Bits 16:0 are copied from the address.
- R7: The protection field has bit 2 = execute, bit 1 = write and bit 0 = read. A fetch needs execute, a store needs write and a load needs read. rspStatus is 1 when granted and 2 on a protection fault. A faulting hit still reports rspHit=1, the real address and the protection bits.
- R8: When no entry matches, the response has rspStatus=0, rspHit=0, rspAddr=0 and rspProt=0.
- R9: rspValid is high exactly in the cycle after a cycle with reqValid high, and low otherwise. Back-to-back requests each get their own result.
- R10: A lookup in the same cycle as a write to the entry it would use sees the contents from before the write. The new contents are used from the next cycle on.
- R11: Reset clears both valid bits of every entry and sets all response outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgCount | input | CNT_W | Number of entries searched per bank |
| wrEn | input | 1 | Write one entry this cycle |
| wrInstrBank | input | 1 | Write target: 1 = instruction bank, 0 = data bank |
| wrIdx | input | IDX_W | Entry index to write |
| wrEpiHi | input | 4 | Upper page field (compared with address bits 31:28) |
| wrEpiLo | input | 11 | Lower page field (compared with address bits 27:17) |
| wrBlen | input | 11 | Block-length mask, contiguous low-order ones |
| wrSupValid | input | 1 | Entry valid in supervisor mode |
| wrUserValid | input | 1 | Entry valid in user mode |
| wrPbn | input | 15 | Physical frame bits for real address bits 31:17 |
| wrProt | input | 3 | Protection: execute, write, read |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Effective address |
| reqType | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor mode |
| rspValid | output | 1 | Result valid |
| rspHit | output | 1 | An entry matched |
| rspAddr | output | 32 | Real address |
| rspProt | output | 3 | Protection bits of the matching entry |
| rspStatus | output | 2 | 0 no match, 1 granted, 2 protection fault |

## Verification
The two functions that can fall in the same cycle are an entry write and a lookup that would select that same entry. The bench drives the write ports and the request ports on the same falling edge. Its scoreboard computes the expected result from its mirror of the table as it stood before the write, so the result must show the old frame. A second lookup in the following cycle must show the new frame.

// File: rtl/batPkg.sv
package batPkg;
  localparam int HI_W   = 4;
  localparam int LO_W   = 11;
  localparam int PBN_W  = HI_W + LO_W;
  localparam int PROT_W = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } accType_e;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_GRANT = 2'd1,
    ST_FAULT = 2'd2
  } status_e;

  typedef struct packed {
    logic [HI_W-1:0]   epiHi;
    logic [LO_W-1:0]   epiLo;
    logic [LO_W-1:0]   blen;
    logic              supValid;
    logic              userValid;
    logic [PBN_W-1:0]  pbn;
    logic [PROT_W-1:0] prot;
  } batEntry_t;

  typedef struct packed {
    logic wrInstr;
    logic wrData;
    logic lookInstr;
    logic needExec;
    logic needWrite;
    logic needRead;
    logic capture;
  } batStrobe_t;
endpackage

// File: rtl/batCtrl.sv
module batCtrl
  import batPkg::*;
(
  input  logic       wrEn,
  input  logic       wrInstrBank,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  output batStrobe_t strobes
);
  logic isFetch;
  logic isStore;

  assign isFetch = (reqType == ACC_FETCH);
  assign isStore = (reqType == ACC_STORE);

  always_comb begin
    strobes.wrInstr   = wrEn & wrInstrBank;
    strobes.wrData    = wrEn & ~wrInstrBank;
    strobes.lookInstr = isFetch;
    strobes.needExec  = isFetch;
    strobes.needWrite = isStore;
    strobes.needRead  = ~isFetch & ~isStore;
    strobes.capture   = reqValid;
  end
endmodule

// File: rtl/batData.sv
module batData
  import batPkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  batStrobe_t       strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  batEntry_t        wrEntry,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [31:0]      reqAddr,
  input  logic             reqUser,
  output logic             rspValid,
  output logic             rspHit,
  output logic [31:0]      rspAddr,
  output logic [2:0]       rspProt,
  output logic [1:0]       rspStatus
);
  batEntry_t instrTab [NUM_ENTRIES];
  batEntry_t dataTab  [NUM_ENTRIES];
  batEntry_t selEntry [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;

  // storage: two banks, written one entry at a time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        instrTab[i] <= '0;
        dataTab[i]  <= '0;
      end
    end else begin
      if (strobes.wrInstr) instrTab[wrIdx] <= wrEntry;
      if (strobes.wrData)  dataTab[wrIdx]  <= wrEntry;
    end
  end

  // per-entry compare against the selected bank
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
    logic inRange;
    logic entValid;
    assign selEntry[g] = strobes.lookInstr ? instrTab[g] : dataTab[g];
    assign inRange     = CNT_W'(g) < cfgCount;
    assign entValid    = reqUser ? selEntry[g].userValid : selEntry[g].supValid;
    assign hitVec[g]   = inRange && entValid &&
                         (reqAddr[31:28] == selEntry[g].epiHi) &&
                         ((reqAddr[27:17] & ~selEntry[g].blen) == selEntry[g].epiLo);
  end

  // lowest index wins
  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  batEntry_t   winEntry;
  logic [31:0] realAddr;
  logic        allowed;
  assign winEntry = selEntry[winIdx];
  assign realAddr = {winEntry.pbn[PBN_W-1:LO_W],
                     (winEntry.pbn[LO_W-1:0] & ~winEntry.blen) |
                     (reqAddr[27:17] & winEntry.blen),
                     reqAddr[16:0]};
  assign allowed  = (strobes.needExec  & winEntry.prot[2]) |
                    (strobes.needWrite & winEntry.prot[1]) |
                    (strobes.needRead  & winEntry.prot[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspAddr   <= '0;
      rspProt   <= '0;
      rspStatus <= ST_MISS;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspHit    <= anyHit;
        rspAddr   <= anyHit ? realAddr : 32'd0;
        rspProt   <= anyHit ? winEntry.prot : 3'd0;
        rspStatus <= !anyHit ? ST_MISS : (allowed ? ST_GRANT : ST_FAULT);
      end
    end
  end
endmodule

// File: rtl/batMatch.sv
module batMatch
  import batPkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             wrEn,
  input  logic             wrInstrBank,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [3:0]       wrEpiHi,
  input  logic [10:0]      wrEpiLo,
  input  logic [10:0]      wrBlen,
  input  logic             wrSupValid,
  input  logic             wrUserValid,
  input  logic [14:0]      wrPbn,
  input  logic [2:0]       wrProt,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqType,
  input  logic             reqUser,
  output logic             rspValid,
  output logic             rspHit,
  output logic [31:0]      rspAddr,
  output logic [2:0]       rspProt,
  output logic [1:0]       rspStatus
);
  batStrobe_t strobes;
  batEntry_t  wrEntry;

  assign wrEntry = '{epiHi: wrEpiHi, epiLo: wrEpiLo, blen: wrBlen,
                     supValid: wrSupValid, userValid: wrUserValid,
                     pbn: wrPbn, prot: wrProt};

  batCtrl uCtrl (
    .wrEn(wrEn), .wrInstrBank(wrInstrBank), .reqValid(reqValid),
    .reqType(reqType), .strobes(strobes)
  );

  batData #(.NUM_ENTRIES(NUM_ENTRIES)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .wrEntry(wrEntry), .cfgCount(cfgCount), .reqAddr(reqAddr),
    .reqUser(reqUser), .rspValid(rspValid), .rspHit(rspHit),
    .rspAddr(rspAddr), .rspProt(rspProt), .rspStatus(rspStatus)
  );
endmodule

// File: rtl/batMatchChk.sv
module batMatchChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic [1:0]  reqType,
  input logic        rspValid,
  input logic        rspHit,
  input logic [31:0] rspAddr,
  input logic [2:0]  rspProt,
  input logic [1:0]  rspStatus
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R9
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspStatus == 2'd0 && rspAddr == 32'd0 && rspProt == 3'd0)); // R8
  AST_HIT_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspStatus == 2'd1 || rspStatus == 2'd2)); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspAddr[16:0] == $past(reqAddr[16:0]))); // R6
  AST_FETCH_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd1 && $past(reqType) == 2'd2) |-> rspProt[2]); // R7
  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd1 && $past(reqType) == 2'd1) |-> rspProt[1]); // R7
endmodule

bind batMatch batMatchChk uBatChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqType(reqType), .rspValid(rspValid), .rspHit(rspHit),
  .rspAddr(rspAddr), .rspProt(rspProt), .rspStatus(rspStatus)
);

// File: tb/tb_batMatch.sv
`timescale 1ns/1ps
module tb_batMatch;
  localparam int NE = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgCount = CW'(NE);
  logic wrEn = 0, wrInstrBank = 0, wrSupValid = 0, wrUserValid = 0;
  logic [IW-1:0] wrIdx = '0;
  logic [3:0] wrEpiHi = '0;
  logic [10:0] wrEpiLo = '0, wrBlen = '0;
  logic [14:0] wrPbn = '0;
  logic [2:0] wrProt = '0;
  logic reqValid = 0, reqUser = 0;
  logic [31:0] reqAddr = '0;
  logic [1:0] reqType = '0;
  logic rspValid, rspHit;
  logic [31:0] rspAddr;
  logic [2:0] rspProt;
  logic [1:0] rspStatus;

  always #4 clk = ~clk;

  batMatch #(.NUM_ENTRIES(NE)) dut (.*);

  typedef struct packed {
    logic [3:0] hi; logic [10:0] lo; logic [10:0] blen;
    logic sv; logic uv; logic [14:0] pbn; logic [2:0] pr;
  } mEnt_t;
  typedef struct {
    logic hit; logic [31:0] ra; logic [2:0] pr; logic [1:0] st; string tag;
  } expItem_t;

  mEnt_t mir [2][NE];
  expItem_t expQ[$];
  int checks = 0, failures = 0;
  int cfgCnt = NE;
  bit pend = 0; int pBank, pIdx; mEnt_t pEnt;

  function automatic expItem_t model(input logic [31:0] a, input logic [1:0] t,
                                     input logic u, input string tag);
    expItem_t e;
    int b = (t == 2'd2) ? 1 : 0;
    bit found = 0;
    e.hit = 0; e.ra = 0; e.pr = 0; e.st = 2'd0; e.tag = tag;
    for (int i = 0; i < NE; i++) begin
      mEnt_t m;
      m = mir[b][i];
      if (!found && i < cfgCnt && (u ? m.uv : m.sv) && a[31:28] == m.hi &&
          ((a[27:17] & ~m.blen) == m.lo)) begin
        logic need;
        found = 1;
        e.hit = 1;
        e.pr = m.pr;
        e.ra = {m.pbn[14:11], (m.pbn[10:0] & ~m.blen) | (a[27:17] & m.blen), a[16:0]};
        need = (t == 2'd2) ? m.pr[2] : (t == 2'd1) ? m.pr[1] : m.pr[0];
        e.st = need ? 2'd1 : 2'd2;
      end
    end
    return e;
  endfunction

  task automatic putWrite(input int bank, input int idx, input logic [3:0] hi,
                          input logic [10:0] lo, input logic [10:0] blen,
                          input logic sv, input logic uv, input logic [14:0] pbn,
                          input logic [2:0] pr);
    wrEn = 1; wrInstrBank = bank[0]; wrIdx = IW'(idx);
    wrEpiHi = hi; wrEpiLo = lo; wrBlen = blen; wrSupValid = sv;
    wrUserValid = uv; wrPbn = pbn; wrProt = pr;
    pend = 1; pBank = bank; pIdx = idx;
    pEnt = '{hi: hi, lo: lo, blen: blen, sv: sv, uv: uv, pbn: pbn, pr: pr};
  endtask

  task automatic putLookup(input logic [31:0] a, input logic [1:0] t,
                           input logic u, input string tag);
    reqValid = 1; reqAddr = a; reqType = t; reqUser = u;
    expQ.push_back(model(a, t, u, tag));
  endtask

  task automatic tick();
    @(posedge clk);
    if (pend) begin mir[pBank][pIdx] = pEnt; pend = 0; end
    @(negedge clk);
    wrEn = 0; reqValid = 0;
  endtask

  task automatic setCount(input int n);
    cfgCnt = n; cfgCount = CW'(n);
  endtask

  // monitor / scoreboard
  always begin
    @(posedge clk); #2;
    if (rstN) begin
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (!rspValid || rspHit !== e.hit || rspAddr !== e.ra ||
            rspProt !== e.pr || rspStatus !== e.st) begin
          failures++;
          $display("FAIL %s actual v=%0b hit=%0b addr=%h prot=%b st=%0d expected v=1 hit=%0b addr=%h prot=%b st=%0d",
                   e.tag, rspValid, rspHit, rspAddr, rspProt, rspStatus,
                   e.hit, e.ra, e.pr, e.st);
        end
      end else if (rspValid) begin
        checks++; failures++;
        $display("FAIL R9 idle cycle actual rspValid=1 expected 0");
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) mir[b][i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (rspValid !== 0 || rspHit !== 0 || rspAddr !== 0 || rspProt !== 0 || rspStatus !== 0) begin
      failures++;
      $display("FAIL R11 reset outputs actual v=%0b hit=%0b addr=%h prot=%b st=%0d expected all 0",
               rspValid, rspHit, rspAddr, rspProt, rspStatus);
    end
    // R11: empty tables miss in both banks
    putLookup(32'h1012_3456, 2'd0, 1'b0, "R11 empty data bank"); tick();
    putLookup(32'h1012_3456, 2'd2, 1'b0, "R11 empty instr bank"); tick();

    // data entry 0: 2 MiB block, read/write, supervisor only
    putWrite(0, 0, 4'h1, 11'h000, 11'h00F, 1, 0, 15'h4020, 3'b011); tick();
    putLookup(32'h1012_3456, 2'd0, 1'b0, "R3 R6 masked hit load"); tick();
    putLookup(32'h1012_3456, 2'd0, 1'b1, "R4 user-invalid entry"); tick();
    putLookup(32'h101F_FFFF, 2'd1, 1'b0, "R7 store granted"); tick();
    putLookup(32'h1012_3456, 2'd2, 1'b0, "R1 fetch ignores data bank"); tick();
    putLookup(32'h2012_3456, 2'd0, 1'b0, "R2 upper field mismatch"); tick();
    putLookup(32'h1020_0000, 2'd0, 1'b0, "R3 bit outside mask"); tick();
    putLookup(32'h1012_3456, 2'd3, 1'b0, "R1 code 3 acts as load"); tick();

    // instruction entries
    putWrite(1, 1, 4'h1, 11'h000, 11'h000, 1, 1, 15'h7001, 3'b100); tick();
    putLookup(32'h1000_1234, 2'd2, 1'b0, "R1 fetch hits instr bank"); tick();
    putLookup(32'h1000_1234, 2'd2, 1'b1, "R4 user valid fetch"); tick();
    putLookup(32'h1000_1234, 2'd0, 1'b0, "R1 load uses data bank"); tick();
    putWrite(1, 2, 4'h3, 11'h000, 11'h000, 1, 0, 15'h0003, 3'b001); tick();
    putLookup(32'h3000_0040, 2'd2, 1'b0, "R7 fetch without execute"); tick();
    putWrite(0, 1, 4'h5, 11'h000, 11'h7FF, 1, 1, 15'h1000, 3'b001); tick();
    putLookup(32'h5ABC_0000, 2'd1, 1'b1, "R7 store to read-only"); tick();

    // priority and search limit
    putWrite(0, 2, 4'h6, 11'h000, 11'h7FF, 1, 0, 15'h2000, 3'b001); tick();
    putWrite(0, 3, 4'h6, 11'h000, 11'h7FF, 1, 0, 15'h3000, 3'b011); tick();
    putLookup(32'h6ABC_DEF0, 2'd0, 1'b0, "R5 lowest index wins"); tick();
    setCount(2);
    putLookup(32'h6ABC_DEF0, 2'd0, 1'b0, "R5 count excludes entries"); tick();
    setCount(3);
    putLookup(32'h6ABC_DEF0, 2'd0, 1'b0, "R5 count boundary"); tick();
    setCount(4);
    putWrite(0, 2, 4'h6, 11'h000, 11'h7FF, 0, 0, 15'h2000, 3'b001); tick();
    putLookup(32'h6ABC_DEF0, 2'd1, 1'b0, "R5 next entry after invalid"); tick();

    // R10: write and lookup in the same cycle
    putWrite(0, 3, 4'h6, 11'h000, 11'h7FF, 1, 0, 15'h5000, 3'b011);
    putLookup(32'h6123_4567, 2'd0, 1'b0, "R10 same-cycle sees old");
    tick();
    putLookup(32'h6123_4567, 2'd0, 1'b0, "R10 next cycle sees new"); tick();

    // R9: back-to-back requests, then idle
    putLookup(32'h1000_0000, 2'd0, 1'b0, "R9 back-to-back first"); tick();
    putLookup(32'h3000_0000, 2'd2, 1'b0, "R9 back-to-back second"); tick();
    putLookup(32'h9000_0000, 2'd0, 1'b0, "R9 back-to-back miss R8"); tick();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule